// File: doc/BRIEF.md
# Unaligned Byte-Addressed Data Memory Port

This block is a load/store port placed in front of a 4096-byte data store. Each cycle a client may present one request made of an address, an access size (byte, halfword or word), a signedness flag for loads, a write enable and write data. Halfword and word accesses may begin at any byte address and may cross a word boundary, or even the top of the address space, without any fault; the port never raises an alignment error and needs no split left/right access pairs.

Storage is organised as four byte-wide banks indexed by the two low address bits, so any four consecutive bytes sit in four different banks and are read or written together in one cycle. Data is big-endian: the byte at the lowest address is the most significant byte of the returned value. Load results appear one clock after the request, extended with zeros or with the sign bit as asked.

Top module: `unaligned_dmem_port`

## Requirements
- R1: A load request (req_i=1, we_i=0) yields rvalid_o=1 and the load result on rdata_o in the next cycle exactly; the result is built from the addressed bytes with the lowest-addressed byte most significant.
- R2: Halfword and word accesses may start at any byte offset; a word load at 0x001 returns the bytes at 0x001, 0x002, 0x003 and 0x004 in that order, most significant first.
- R3: Only addr_i[11:0] selects the byte; bits 31 to 12 of addr_i have no effect on loads or stores.
- R4: Bytes of an access that pass 0xFFF continue at 0x000 and upward.
- R5: size_i encodes 2'b00 as one byte, 2'b01 as two bytes, and both 2'b10 and 2'b11 as four bytes.
- R6: With signed_i=0 a byte or halfword load is zero-extended to 32 bits; with signed_i=1 it is extended with bit 7 (byte) or bit 15 (halfword); signed_i has no effect on word loads.
- R7: A store of n bytes writes wdata_i[8n-1:0] to the n addressed bytes, most significant byte at the lowest address, and leaves every other byte unchanged.
- R8: A load issued in the cycle after a store returns the freshly stored bytes wherever the two accesses overlap.
- R9: After reset, in idle cycles and in the cycle after a store, rvalid_o=0 and rdata_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request present this cycle |
| we_i | input | 1 | 1 = store, 0 = load |
| size_i | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| signed_i | input | 1 | Sign-extend byte/halfword load results |
| addr_i | input | 32 | Byte address; only bits 11:0 used |
| wdata_i | input | 32 | Store data, right-justified |
| rvalid_o | output | 1 | Load result valid |
| rdata_o | output | 32 | Load result, zero when rvalid_o is low |

## Verification
The two functions that meet in one cycle are the store path writing the banks and the load path reading them: a store is followed directly by a load that overlaps it, often straddling a word edge or the wrap at 0xFFF, so the load's bank read happens on the edge right after the write. A behavioural byte-array model in the bench applies every store before computing the next load's expected value, and each cycle the port's result is compared against it, so a stale byte, a wrong lane or a lost write shows up as a mismatch.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int CNT_W  = OFF_W + 1;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_WRD2 = 2'b11
  } acc_size_e;

  function automatic logic [CNT_W-1:0] acc_bytes(acc_size_e s);
    case (s)
      ACC_BYTE: return CNT_W'(1);
      ACC_HALF: return CNT_W'(2);
      default:  return CNT_W'(LANES);
    endcase
  endfunction
endpackage

// File: rtl/dmem_lane_map.sv
module dmem_lane_map
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int ROW_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  acc_size_e                    size_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [LANES-1:0]             en_o,
  output logic [LANES-1:0][ROW_W-1:0]  row_o,
  output logic [LANES-1:0][7:0]        wbyte_o
);
  logic [CNT_W-1:0] nbytes;
  assign nbytes = acc_bytes(size_i);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [OFF_W-1:0]  k;    // position of this lane's byte within the access
    logic [ADDR_W-1:0] badr;
    logic [CNT_W-1:0]  sel;  // byte index from the lsb of wdata
    logic [DATA_W-1:0] shifted;
    assign k       = OFF_W'(b) - addr_i[OFF_W-1:0];
    assign badr    = addr_i + ADDR_W'(k);
    assign sel     = nbytes - CNT_W'(1) - CNT_W'(k);
    assign shifted = wdata_i >> {sel, 3'b000};
    assign en_o[b]    = CNT_W'(k) < nbytes;
    assign row_o[b]   = badr[ADDR_W-1:OFF_W];
    assign wbyte_o[b] = shifted[7:0];
  end
endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
  parameter int ROW_W = 10,
  localparam int DEPTH = 1 << ROW_W
) (
  input  logic             clk_i,
  input  logic             en_i,
  input  logic             we_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem[row_i] <= wdata_i;
      else      rdata_o    <= mem[row_i];
    end
  end
endmodule

// File: rtl/dmem_load_align.sv
module dmem_load_align
  import dmem_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [OFF_W-1:0]      off_i,
  input  acc_size_e             size_i,
  input  logic                  signed_i,
  input  logic [LANES-1:0][7:0] lane_i,
  output logic [DATA_W-1:0]     data_o
);
  logic [DATA_W-1:0] packed_w;

  always_comb begin
    packed_w = '0;
    for (int k = 0; k < LANES; k++) begin
      packed_w = {packed_w[DATA_W-9:0], lane_i[off_i + OFF_W'(k)]};
    end
  end

  always_comb begin
    unique case (size_i)
      ACC_BYTE: data_o = {{(DATA_W-8){signed_i & packed_w[DATA_W-1]}},
                          packed_w[DATA_W-1 -: 8]};
      ACC_HALF: data_o = {{(DATA_W-16){signed_i & packed_w[DATA_W-1]}},
                          packed_w[DATA_W-1 -: 16]};
      default:  data_o = packed_w;
    endcase
    if (!valid_i) data_o = '0;
  end

  // R6: unsigned narrow loads carry no upper bits
  a_r6_zero_ext_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !signed_i && size_i == ACC_BYTE) |-> data_o[DATA_W-1:8] == '0);
  a_r6_zero_ext_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !signed_i && size_i == ACC_HALF) |-> data_o[DATA_W-1:16] == '0);
  a_r6_sign_ext_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && signed_i && size_i == ACC_BYTE) |->
      (data_o[DATA_W-1:7] == '0 || data_o[DATA_W-1:7] == '1));
endmodule

// File: rtl/unaligned_dmem_port.sv
module unaligned_dmem_port
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int ROW_W = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [31:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o
);
  acc_size_e                   size_in;
  logic [LANES-1:0]            map_en;
  logic [LANES-1:0]            bank_en;
  logic [LANES-1:0][ROW_W-1:0] bank_row;
  logic [LANES-1:0][7:0]       bank_wd;
  logic [LANES-1:0][7:0]       bank_rd;
  logic                        rvalid_q;
  logic [OFF_W-1:0]            off_q;
  acc_size_e                   size_q;
  logic                        sgn_q;
  logic                        unused_addr_hi;

  assign size_in        = acc_size_e'(size_i);
  assign unused_addr_hi = ^addr_i[31:ADDR_W];  // high address bits ignored

  dmem_lane_map #(.ADDR_W(ADDR_W)) i_map (
    .addr_i (addr_i[ADDR_W-1:0]),
    .size_i (size_in),
    .wdata_i(wdata_i),
    .en_o   (map_en),
    .row_o  (bank_row),
    .wbyte_o(bank_wd)
  );

  assign bank_en = map_en & {LANES{req_i}};

  for (genvar b = 0; b < LANES; b++) begin : g_bank
    dmem_bank #(.ROW_W(ROW_W)) i_bank (
      .clk_i  (clk_i),
      .en_i   (bank_en[b]),
      .we_i   (we_i),
      .row_i  (bank_row[b]),
      .wdata_i(bank_wd[b]),
      .rdata_o(bank_rd[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      off_q    <= '0;
      size_q   <= ACC_BYTE;
      sgn_q    <= 1'b0;
    end else begin
      rvalid_q <= req_i & ~we_i;
      if (req_i && !we_i) begin
        off_q  <= addr_i[OFF_W-1:0];
        size_q <= size_in;
        sgn_q  <= signed_i;
      end
    end
  end

  dmem_load_align i_align (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (rvalid_q),
    .off_i   (off_q),
    .size_i  (size_q),
    .signed_i(sgn_q),
    .lane_i  (bank_rd),
    .data_o  (rdata_o)
  );

  assign rvalid_o = rvalid_q;

  a_r1_load_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (!rvalid_o && rdata_o == '0));
  a_r7_store_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |-> ($countones(bank_en) == int'(acc_bytes(size_in))));
  a_r5_word_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i[1]) |-> bank_en == '1);
endmodule

// File: tb/test_unaligned_dmem_port.sv
`timescale 1ns/1ps
module test_unaligned_dmem_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, sgn = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [31:0] addr = '0, wdata = '0;
  logic        rvalid;
  logic [31:0] rdata;

  int compared = 0, mismatched = 0;
  byte unsigned model [4096];
  logic        exp_valid = 1'b0;
  logic [31:0] exp_data = '0;
  string       exp_tag = "R9 reset";

  always #4 clk = ~clk;

  unaligned_dmem_port i_unaligned_dmem_port (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .size_i(size),
    .signed_i(sgn), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata)
  );

  function automatic int nb(logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  task automatic step(input logic rq, input logic w, input logic [1:0] sz,
                      input logic sg, input logic [31:0] ad,
                      input logic [31:0] wd, input string tag);
    int n;
    logic [31:0] v;
    compared++;
    if (rvalid !== exp_valid || rdata !== exp_data) begin
      mismatched++;
      $display("FAIL %s: actual valid=%0b data=%08h expected valid=%0b data=%08h",
               exp_tag, rvalid, rdata, exp_valid, exp_data);
    end
    n = nb(sz);
    exp_valid = rq && !w;
    exp_data  = '0;
    exp_tag   = tag;
    if (rq && w) begin
      for (int k = 0; k < n; k++)
        model[(ad[11:0] + k) & 12'hFFF] = 8'(wd >> (8 * (n - 1 - k)));
    end else if (rq) begin
      v = '0;
      for (int k = 0; k < n; k++)
        v = (v << 8) | 32'(model[(ad[11:0] + k) & 12'hFFF]);
      if (sg && n == 1 && v[7])  v |= 32'hFFFF_FF00;
      if (sg && n == 2 && v[15]) v |= 32'hFFFF_0000;
      exp_data = v;
    end
    req = rq; we = w; size = sz; sgn = sg; addr = ad; wdata = wd;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    step(0, 0, 2'b00, 0, 0, 0, "R9 idle");
    // fill memory with a known pattern (R7 word stores)
    for (int i = 0; i < 1024; i++)
      step(1, 1, 2'b10, 0, 32'(4 * i), 32'(i) * 32'h9E37_79B1 + 32'h1234_5678, "R9 after store");
    step(1, 0, 2'b10, 0, 32'h0000_0001, 0, "R2 word at 0x001");
    step(1, 0, 2'b01, 0, 32'h0000_0003, 0, "R2 half straddle");
    step(1, 0, 2'b10, 0, 32'h0000_0FFE, 0, "R4 word wrap");
    step(1, 1, 2'b10, 0, 32'h0000_0FFD, 32'hA1B2_C3D4, "R9 after store");
    step(1, 0, 2'b10, 0, 32'h0000_0FFD, 0, "R4 R8 store wrap readback");
    step(1, 0, 2'b01, 0, 32'h0000_0FFF, 0, "R4 half wrap");
    step(1, 0, 2'b10, 0, 32'hABCD_E001, 0, "R3 high bits ignored load");
    step(1, 1, 2'b00, 0, 32'h7777_7010, 32'hFFFF_FF80, "R3 R7 store high bits");
    step(1, 0, 2'b00, 1, 32'h0000_0010, 0, "R6 signed byte");
    step(1, 0, 2'b00, 0, 32'h0000_0010, 0, "R6 unsigned byte");
    step(1, 1, 2'b01, 0, 32'h0000_0013, 32'h0000_8123, "R9 after store");
    step(1, 0, 2'b01, 1, 32'h0000_0013, 0, "R6 signed half");
    step(1, 0, 2'b01, 0, 32'h0000_0013, 0, "R6 unsigned half");
    step(1, 0, 2'b10, 1, 32'h0000_0012, 0, "R6 signed word unaffected");
    step(1, 1, 2'b01, 0, 32'h0000_0021, 32'hDEAD_5AA5, "R9 after store");
    step(1, 0, 2'b10, 0, 32'h0000_0020, 0, "R7 neighbours intact");
    step(1, 0, 2'b10, 0, 32'h0000_0022, 0, "R7 neighbours intact");
    step(1, 0, 2'b11, 0, 32'h0000_0021, 0, "R5 size 11 is word");
    step(0, 1, 2'b10, 0, 32'h0000_0040, 32'hFFFF_FFFF, "R9 no req no write");
    step(1, 0, 2'b10, 0, 32'h0000_0040, 0, "R7 unrequested write ignored");
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] ra = $urandom;
      logic [31:0] rw = $urandom;
      logic [3:0]  rc = 4'($urandom);
      if (rc[3:2] == 2'b00) ra[11:0] = 12'hFFC | 12'(ra[1:0]);
      step(rc != 4'hF, rc[0] & rc[1], 2'(rc >> 1), rc[2], ra, rw,
           (rc[0] & rc[1]) ? "R9 after store" : "R1 R8 random mix");
    end
    step(0, 0, 2'b00, 0, 0, 0, "R9 idle end");
    step(0, 0, 2'b00, 0, 0, 0, "R9 idle end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule